// File: doc/BRIEF.md
# Next-PC Selector for a Four-Stage Pipeline

This block chooses the address the fetch stage uses on the next clock of a four-stage pipeline with fetch, operand-fetch, execute and write-back stages. It looks at the control word of the instruction in execute. That word carries a two-bit transfer code, a condition-polarity bit and the zero flag from the function unit. From these the block picks one of three candidate addresses: the incremented PC, the branch target computed by an external adder, or a register value. It also holds the program counter register.

A single set of signals covers sequential flow, branches on zero or non-zero, jump-and-link and jump-register. The two-bit source code is formed as {code[1], code[0] AND (code[1] OR (polarity XOR zero))}. By the time a branch resolves in execute, two younger instructions have already been fetched. When control is transferred, the block raises a flush so the surrounding pipeline can turn those two instructions into no-ops. A build option instead leaves them to run as two delay slots.

A stall input freezes the PC during data-hazard stalls. While it is high, the transfer code is ignored.

Top module: `npc_selector`

## Requirements
- R1: A synchronous reset loads `pc_q` with the parameter `RST_PC`, which defaults to 0.
- R2: With `bs` = 00, `pc_sel` = 0, `next_pc` equals `pc_inc` and `flush` is low, whatever the values of `ps` and `zero`.
- R3: With `bs` = 01 and `ps` = 0 (branch on zero): if `zero` = 1, then `pc_sel` = 1 and `next_pc` = `br_addr`; if `zero` = 0, then `pc_sel` = 0 and `next_pc` = `pc_inc`.
- R4: With `bs` = 01 and `ps` = 1 (branch on non-zero): if `zero` = 0, then `pc_sel` = 1 and `next_pc` = `br_addr`; if `zero` = 1, then `pc_sel` = 0 and `next_pc` = `pc_inc`.
- R5: With `bs` = 10 (jump to register), `pc_sel` = 2 and `next_pc` = `jr_addr`, whatever the values of `ps` and `zero`.
- R6: With `bs` = 11 (unconditional jump, used for jump-and-link), `pc_sel` = 3 and `next_pc` = `br_addr`, whatever the values of `ps` and `zero`.
- R7: When `FLUSH_ON_TAKEN` = 1, `flush` is high in exactly the cycles where `pc_sel` is not 0 and `stall` is low.
- R8: While `stall` is high, `pc_q` keeps its value on the next edge and `flush` stays low, whatever the transfer code is.
- R9: While neither `stall` nor `rst` is high, `pc_q` takes the value that `next_pc` showed before each rising edge.
- R10: When `FLUSH_ON_TAKEN` = 0 (delay-slot mode), `flush` never rises, and address selection is the same as in R2 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Hold the PC and ignore the transfer code |
| bs | input | 2 | Execute-stage transfer code |
| ps | input | 1 | Condition polarity (0 = branch on zero) |
| zero | input | 1 | Zero flag from the function unit |
| br_addr | input | PC_W | Branch target (PC+1 plus the sign-extended offset) |
| jr_addr | input | PC_W | Register jump address |
| pc_inc | input | PC_W | Incremented PC |
| next_pc | output | PC_W | Selected next address |
| pc_sel | output | 2 | Source index: 0 = inc, 1 and 3 = target, 2 = register |
| pc_q | output | PC_W | Program counter register |
| flush | output | 1 | Cancel the two younger instructions |

## Verification
The bench builds two copies. The first uses the default 32-bit PC with flushing enabled. The second uses a 16-bit PC with `FLUSH_ON_TAKEN` = 0. The wide copy exposes every address bit, so a mux input wired to the wrong leg shows up as a wrong value. The narrow delay-slot copy runs the same 16 transfer-code/polarity/zero combinations and must select identically with `flush` held low. Running both copies through every combination covers both the polarity XOR and the other variant of the generate choice.

// File: rtl/npc_pkg.sv
package npc_pkg;
   typedef enum logic [1:0] {
      NPC_SEQ = 2'd0,
      NPC_BR  = 2'd1,
      NPC_JR  = 2'd2,
      NPC_JMP = 2'd3
   } npc_src_e;
endpackage

// File: rtl/npc_sel_decode.sv
module npc_sel_decode
   import npc_pkg::*;
(
   input  logic [1:0] bs,
   input  logic       ps,
   input  logic       zero,
   output npc_src_e   src
);
   logic cond_hit;
   assign cond_hit = ps ^ zero;
   assign src = npc_src_e'({bs[1], bs[0] & (bs[1] | cond_hit)});
endmodule

// File: rtl/npc_mux.sv
module npc_mux
   import npc_pkg::*;
#(
   parameter int W = 32
) (
   input  npc_src_e     src,
   input  logic [W-1:0] inc,
   input  logic [W-1:0] br,
   input  logic [W-1:0] jr,
   output logic [W-1:0] nxt
);
   always_comb begin
      case (src)
         NPC_SEQ: nxt = inc;
         NPC_JR:  nxt = jr;
         default: nxt = br;
      endcase
   end
endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg #(
   parameter int           W       = 32,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         hold,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)       q <= RST_VAL;
      else if (!hold) q <= d;
   end
endmodule

// File: rtl/npc_selector.sv
module npc_selector
   import npc_pkg::*;
#(
   parameter int              PC_W           = 32,
   parameter logic [PC_W-1:0] RST_PC         = '0,
   parameter bit              FLUSH_ON_TAKEN = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            stall,
   input  logic [1:0]      bs,
   input  logic            ps,
   input  logic            zero,
   input  logic [PC_W-1:0] br_addr,
   input  logic [PC_W-1:0] jr_addr,
   input  logic [PC_W-1:0] pc_inc,
   output logic [PC_W-1:0] next_pc,
   output logic [1:0]      pc_sel,
   output logic [PC_W-1:0] pc_q,
   output logic            flush
);
   if (PC_W < 2 || PC_W > 64) begin : g_bad_width
      $error("npc_selector: PC_W must lie in 2..64");
   end

   npc_src_e src;

   npc_sel_decode u_dec (
      .bs   (bs),
      .ps   (ps),
      .zero (zero),
      .src  (src)
   );

   npc_mux #(.W(PC_W)) u_mux (
      .src (src),
      .inc (pc_inc),
      .br  (br_addr),
      .jr  (jr_addr),
      .nxt (next_pc)
   );

   npc_pc_reg #(.W(PC_W), .RST_VAL(RST_PC)) u_pc (
      .clk  (clk),
      .rst  (rst),
      .hold (stall),
      .d    (next_pc),
      .q    (pc_q)
   );

   assign pc_sel = src;

   if (FLUSH_ON_TAKEN) begin : g_squash
      assign flush = (src != NPC_SEQ) & ~stall;
   end else begin : g_delay_slot
      assign flush = 1'b0;
   end
endmodule

// File: rtl/npc_selector_chk.sv
module npc_selector_chk #(
   parameter int              PC_W           = 32,
   parameter logic [PC_W-1:0] RST_PC         = '0,
   parameter bit              FLUSH_ON_TAKEN = 1'b1
) (
   input logic            clk,
   input logic            rst,
   input logic            stall,
   input logic [1:0]      bs,
   input logic            ps,
   input logic            zero,
   input logic [PC_W-1:0] br_addr,
   input logic [PC_W-1:0] jr_addr,
   input logic [PC_W-1:0] pc_inc,
   input logic [PC_W-1:0] next_pc,
   input logic [1:0]      pc_sel,
   input logic [PC_W-1:0] pc_q,
   input logic            flush
);
   p_reset_pc_r1: assert property (@(posedge clk) rst |=> pc_q == RST_PC);

   p_seq_r2: assert property (@(posedge clk) disable iff (rst)
      bs == 2'b00 |-> (next_pc == pc_inc) && (pc_sel == 2'd0));

   p_jr_r5: assert property (@(posedge clk) disable iff (rst)
      bs == 2'b10 |-> next_pc == jr_addr);

   p_jmp_r6: assert property (@(posedge clk) disable iff (rst)
      bs == 2'b11 |-> next_pc == br_addr);

   p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
      stall |=> $stable(pc_q));

   p_stall_noflush_r8: assert property (@(posedge clk) disable iff (rst)
      stall |-> !flush);

   p_load_r9: assert property (@(posedge clk) disable iff (rst)
      !stall |=> pc_q == $past(next_pc));

   if (FLUSH_ON_TAKEN) begin : g_chk_squash
      p_flush_r7: assert property (@(posedge clk) disable iff (rst)
         (pc_sel != 2'd0 && !stall) |-> flush);
   end else begin : g_chk_slot
      p_no_flush_r10: assert property (@(posedge clk) disable iff (rst)
         !flush);
   end
endmodule

bind npc_selector npc_selector_chk #(
   .PC_W(PC_W), .RST_PC(RST_PC), .FLUSH_ON_TAKEN(FLUSH_ON_TAKEN)
) u_chk (.*);

// File: tb/tb_npc_selector.sv
module tb_npc_selector;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        stall = 1'b0;
   logic [1:0]  bs = 2'b00;
   logic        ps = 1'b0;
   logic        zero = 1'b0;
   logic [31:0] br_addr = '0, jr_addr = '0, pc_inc = '0;
   logic [31:0] next_pc, pc_q;
   logic [1:0]  pc_sel;
   logic        flush;
   logic [15:0] ds_next, ds_q;
   logic [1:0]  ds_sel;
   logic        ds_flush;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   npc_selector dut (
      .clk(clk), .rst(rst), .stall(stall), .bs(bs), .ps(ps), .zero(zero),
      .br_addr(br_addr), .jr_addr(jr_addr), .pc_inc(pc_inc),
      .next_pc(next_pc), .pc_sel(pc_sel), .pc_q(pc_q), .flush(flush)
   );

   npc_selector #(.PC_W(16), .FLUSH_ON_TAKEN(1'b0)) dut_ds (
      .clk(clk), .rst(rst), .stall(stall), .bs(bs), .ps(ps), .zero(zero),
      .br_addr(br_addr[15:0]), .jr_addr(jr_addr[15:0]), .pc_inc(pc_inc[15:0]),
      .next_pc(ds_next), .pc_sel(ds_sel), .pc_q(ds_q), .flush(ds_flush)
   );

   // {bs, ps, zero, expected pc_sel}
   localparam logic [5:0] VEC [16] = '{
      6'b00_0_0_00, 6'b00_0_1_00, 6'b00_1_0_00, 6'b00_1_1_00,
      6'b01_0_0_00, 6'b01_0_1_01, 6'b01_1_0_01, 6'b01_1_1_00,
      6'b10_0_0_10, 6'b10_0_1_10, 6'b10_1_0_10, 6'b10_1_1_10,
      6'b11_0_0_11, 6'b11_0_1_11, 6'b11_1_0_11, 6'b11_1_1_11
   };

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic string req_of(logic [1:0] b, logic p);
      if (b == 2'b00) return "R2";
      if (b == 2'b01) return p ? "R4" : "R3";
      if (b == 2'b10) return "R5";
      return "R6";
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset pc", pc_q, 32'h0);
      rst = 1'b0;
      for (int i = 0; i < 16; i++) begin
         logic [1:0]  esel;
         logic [31:0] epc;
         string       r;
         bs = VEC[i][5:4]; ps = VEC[i][3]; zero = VEC[i][2];
         esel = VEC[i][1:0];
         pc_inc  = 32'h1000_0000 + i;
         br_addr = 32'h2000_0000 + 32'h11 * i;
         jr_addr = 32'h3000_0000 + 32'h101 * i;
         epc = (esel == 2'd0) ? pc_inc : (esel == 2'd2) ? jr_addr : br_addr;
         r = req_of(bs, ps);
         #1;
         chk(r, {30'd0, pc_sel}, {30'd0, esel});
         chk(r, next_pc, epc);
         chk("R7 flush", {31'd0, flush}, {31'd0, esel != 2'd0});
         chk("R10 delay-slot select", {16'd0, ds_next}, {16'd0, epc[15:0]});
         chk("R10 delay-slot flush", {31'd0, ds_flush}, 32'd0);
         @(negedge clk);
         chk("R9 pc load", pc_q, epc);
      end
      // stall with an unconditional jump pending
      begin
         logic [31:0] held;
         held = pc_q;
         stall = 1'b1; bs = 2'b11; br_addr = 32'hDEAD_0000;
         #1;
         chk("R8 flush under stall", {31'd0, flush}, 32'd0);
         @(negedge clk);
         chk("R8 pc held", pc_q, held);
         bs = 2'b10; jr_addr = 32'h0000_BEEF;
         @(negedge clk);
         chk("R8 pc held jr", pc_q, held);
         stall = 1'b0;
         #1;
         chk("R7 flush after stall", {31'd0, flush}, 32'd1);
         @(negedge clk);
         chk("R9 pc after stall", pc_q, 32'h0000_BEEF);
      end
      // reset mid-run, with a jump offered
      rst = 1'b1; bs = 2'b11; br_addr = 32'h5555_5555;
      @(negedge clk);
      chk("R1 reset mid-run", pc_q, 32'h0);
      chk("R1 reset mid-run ds", {16'd0, ds_q}, 32'h0);
      rst = 1'b0; bs = 2'b00; pc_inc = 32'h0000_0001;
      @(negedge clk);
      chk("R2 sequential after reset", pc_q, 32'h1);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule